// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Sequencer

This block is a synchronous controller placed between a simple request/acknowledge host port and an asynchronous-strobe EDO DRAM of 2M words by 8 bits. A host word address is split into a row part and a column part, and both go out on one multiplexed address bus. The block generates the row strobe, the column strobe, the write enable and the output enable. It also drives an output-enable-qualified data bus towards the memory and captures read data coming back from it.

The sequencer keeps a row open after an access. A later request to the same row runs as another fast column cycle (EDO page hit), and RAS stays low. A request to a different row, or an open row that has used up its RAS-low budget, closes the row. The row then precharges before the next one opens. Writes are early writes: WE falls and write data is driven before CAS falls. Read data is captured a fixed number of clocks after CAS falls, which may be after CAS has risen again, since the EDO output holds its data until the next column strobe. Every timing minimum is a parameter counted in controller clocks. Refresh is left to a separate block: it requests the memory, and this sequencer closes the row and grants it.

Top module: `edo_page_seq`

## Requirements
- R1: The row is the upper ROW_W bits of the host address and is placed on `dram_a` before RAS falls. The column is the lower COL_W bits, zero-extended to the pin width, and is placed on `dram_a` before CAS falls. `dram_a` stays stable while CAS is low.
- R2: The strobes honour these minimums, in clocks: RAS fall to CAS fall at least T_RCD, RAS high at least T_RP, RAS low at least T_RAS, CAS low at least T_CAS, and CAS high between column cycles at least T_CP.
- R3: A request whose row equals the open row runs as a new CAS cycle while RAS stays low.
- R4: A request to another row raises RAS once T_RAS is met. It then waits T_RP and opens the requested row.
- R5: RAS is never low for more than RAS_MAX clocks. A page hit is only accepted if its column cycle fits in the remaining budget; otherwise the row is closed first.
- R6: Early write: WE is low and write data is driven (`dram_dq_oe`=1) before CAS falls, and both are held while CAS is low. Written data reads back unchanged.
- R7: A read has WE high and OE low at CAS fall. `rd_data` is sampled and `rd_valid` pulses for exactly one clock, RD_LAT clock edges after the edge on which CAS fell.
- R8: `dram_dq_oe` is never 1 while `dram_oe_n` is 0. The controller drives the data bus only in write column cycles.
- R9: `ack` is a one-clock pulse on the edge after a request is accepted. Each request gets exactly one `ack`.
- R10: While `ref_req` is high, the open row is closed and precharged. `ref_gnt` then rises with RAS, CAS and OE high and the bus released. No host request is accepted while the grant is held.
- R11: During reset all strobes are high, the data bus is released, and `ack`, `rd_valid` and `ref_gnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, held until ack |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in upper bits |
| req_wdata | input | DW | Write data |
| ack | output | 1 | Request accepted pulse |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DW | Captured read data |
| ref_req | input | 1 | Refresh block asks for the memory |
| ref_gnt | output | 1 | Memory handed to the refresh block |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_a | output | max(ROW_W,COL_W) | Multiplexed address pins |
| dram_dq_out | output | DW | Data driven to memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DW | Data read from memory |

## Verification
`ack` is due on the clock edge after acceptance, and `rd_valid` is due exactly RD_LAT edges after the edge on which CAS fell. The bench timestamps each CAS fall at the following falling clock edge and compares it with the `rd_valid` timestamp. A behavioural memory model only presents read data two clocks after CAS falls and only while OE is low, so capturing too early or with OE released returns a wrong byte. The number of row openings for each sweep is computed arithmetically from the RAS budget, T_RCD, T_CAS, T_CP and the one-clock host handshake gap, and compared with the count of RAS falls.

// File: rtl/edo_seq_pkg.sv
`timescale 1ns/1ps
package edo_seq_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_RSET, S_RCD, S_CSET, S_CLO, S_CHI, S_OPEN, S_PRE, S_REFG
   } seq_state_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/edo_tick_timer.sv
`timescale 1ns/1ps
module edo_tick_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt;

   assign done = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - W'(1);
   end
endmodule

// File: rtl/edo_addr_split.sv
`timescale 1ns/1ps
module edo_addr_split #(
   parameter int ROW_W = 11,
   parameter int COL_W = 10,
   localparam int AW   = ROW_W + COL_W
) (
   input  logic [AW-1:0]    addr,
   input  logic [ROW_W-1:0] open_row,
   output logic [ROW_W-1:0] row,
   output logic [ROW_W-1:0] col_pin,
   output logic             hit
);
   logic [COL_W-1:0] col;

   assign row = addr[AW-1:COL_W];
   assign col = addr[COL_W-1:0];
   assign hit = (row == open_row);

   generate
      if (ROW_W > COL_W) begin : g_pad
         assign col_pin = {{(ROW_W-COL_W){1'b0}}, col};
      end else begin : g_flat
         assign col_pin = col;
      end
   endgenerate
endmodule

// File: rtl/edo_rd_capture.sv
`timescale 1ns/1ps
module edo_rd_capture #(
   parameter int DW     = 8,
   parameter int RD_LAT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] dq_in,
   output logic          fire,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data
);
   localparam int LW = $clog2(RD_LAT + 1);
   logic [LW-1:0] lat;

   assign fire = (lat == LW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat      <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= fire;
         if (fire) rd_data <= dq_in;
         if (start)           lat <= LW'(RD_LAT);
         else if (lat != '0)  lat <= lat - LW'(1);
      end
   end

   // R7: a new read column cycle never starts while a capture is still pending
   a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (lat == '0));
endmodule

// File: rtl/edo_page_seq.sv
`timescale 1ns/1ps
module edo_page_seq
   import edo_seq_pkg::*;
#(
   parameter int ROW_W   = 11,
   parameter int COL_W   = 10,
   parameter int DW      = 8,
   parameter int T_RCD   = 5,
   parameter int T_RP    = 6,
   parameter int T_RAS   = 10,
   parameter int T_CAS   = 2,
   parameter int T_CP    = 2,
   parameter int RD_LAT  = 4,
   parameter int RAS_MAX = 2000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req,
   input  logic                   req_wr,
   input  logic [ROW_W+COL_W-1:0] req_addr,
   input  logic [DW-1:0]          req_wdata,
   output logic                   ack,
   output logic                   rd_valid,
   output logic [DW-1:0]          rd_data,
   input  logic                   ref_req,
   output logic                   ref_gnt,
   output logic                   dram_ras_n,
   output logic                   dram_cas_n,
   output logic                   dram_we_n,
   output logic                   dram_oe_n,
   output logic [ROW_W-1:0]       dram_a,
   output logic [DW-1:0]          dram_dq_out,
   output logic                   dram_dq_oe,
   input  logic [DW-1:0]          dram_dq_in
);
   localparam int PAGE_LEN = 1 + T_CAS + T_CP;
   localparam int TMAX     = max2(max2(T_RCD, T_RP), max2(T_CAS, T_CP));
   localparam int TW       = $clog2(TMAX + 1);
   localparam int RCW      = $clog2(RAS_MAX + PAGE_LEN + 3) + 1;

   generate
      if (ROW_W < COL_W) begin : g_chk_w
         $error("ROW_W must be at least COL_W");
      end
      if (T_RCD < 1 || T_RP < 1 || T_RAS < 1 || T_CAS < 1 || T_CP < 1) begin : g_chk_t
         $error("timing counts must be at least one clock");
      end
      if (RD_LAT < 1 || RD_LAT > T_CAS + T_CP) begin : g_chk_lat
         $error("RD_LAT must lie in 1..T_CAS+T_CP");
      end
      if (RAS_MAX < T_RAS || RAS_MAX < T_RCD + PAGE_LEN + 2) begin : g_chk_max
         $error("RAS_MAX too small for one access");
      end
   endgenerate

   seq_state_t state, nxt;
   logic              take, tm_load, tm_done, pend;
   logic [TW-1:0]     tm_val;
   logic [RCW-1:0]    ras_cnt;
   logic              ras_ok, room;
   logic [ROW_W-1:0]  m_row, m_col, cur_row, cur_col;
   logic              m_hit, cur_wr, fire, rd_start;
   logic [DW-1:0]     cur_wd;

   edo_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
      .addr(req_addr), .open_row(cur_row),
      .row(m_row), .col_pin(m_col), .hit(m_hit));

   edo_tick_timer #(.W(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val), .done(tm_done));

   assign rd_start = (state == S_CSET) && !cur_wr;

   edo_rd_capture #(.DW(DW), .RD_LAT(RD_LAT)) u_cap (
      .clk(clk), .rst_n(rst_n), .start(rd_start), .dq_in(dram_dq_in),
      .fire(fire), .rd_valid(rd_valid), .rd_data(rd_data));

   assign ras_ok = (int'(ras_cnt) + 1 >= T_RAS);
   assign room   = (int'(ras_cnt) + 2 + PAGE_LEN <= RAS_MAX);

   always_comb begin
      nxt     = state;
      take    = 1'b0;
      tm_load = 1'b0;
      tm_val  = '0;
      unique case (state)
         S_IDLE: begin
            if (ref_req) nxt = S_REFG;
            else if (req) begin
               take = 1'b1;
               nxt  = S_RSET;
            end
         end
         S_RSET: begin
            nxt = S_RCD; tm_load = 1'b1; tm_val = TW'(T_RCD - 1);
         end
         S_RCD: if (tm_done) nxt = S_CSET;
         S_CSET: begin
            nxt = S_CLO; tm_load = 1'b1; tm_val = TW'(T_CAS - 1);
         end
         S_CLO: if (tm_done) begin
            nxt = S_CHI; tm_load = 1'b1; tm_val = TW'(T_CP - 1);
         end
         S_CHI: if (tm_done) nxt = S_OPEN;
         S_OPEN: begin
            if (ref_req || !room) begin
               if (ras_ok) begin
                  nxt = S_PRE; tm_load = 1'b1; tm_val = TW'(T_RP - 1);
               end
            end else if (req) begin
               if (m_hit) begin
                  take = 1'b1; nxt = S_CSET;
               end else if (ras_ok) begin
                  take = 1'b1; nxt = S_PRE;
                  tm_load = 1'b1; tm_val = TW'(T_RP - 1);
               end
            end
         end
         S_PRE: if (tm_done) nxt = pend ? S_RSET : S_IDLE;
         S_REFG: if (!ref_req) nxt = S_IDLE;
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         dram_ras_n  <= 1'b1;
         dram_cas_n  <= 1'b1;
         dram_we_n   <= 1'b1;
         dram_oe_n   <= 1'b1;
         dram_dq_oe  <= 1'b0;
         dram_dq_out <= '0;
         dram_a      <= '0;
         ack         <= 1'b0;
         ref_gnt     <= 1'b0;
         ras_cnt     <= '0;
         pend        <= 1'b0;
         cur_row     <= '0;
         cur_col     <= '0;
         cur_wr      <= 1'b0;
         cur_wd      <= '0;
      end else begin
         state   <= nxt;
         ack     <= take;
         ref_gnt <= (nxt == S_REFG);
         if (take) begin
            cur_row <= m_row;
            cur_col <= m_col;
            cur_wr  <= req_wr;
            cur_wd  <= req_wdata;
         end
         if (take && nxt == S_PRE) pend <= 1'b1;
         if (nxt == S_RSET) begin
            dram_a <= take ? m_row : cur_row;
            pend   <= 1'b0;
         end
         if (state == S_RSET) begin
            dram_ras_n <= 1'b0;
            ras_cnt    <= '0;
         end else if (!dram_ras_n && ras_cnt != {RCW{1'b1}}) begin
            ras_cnt <= ras_cnt + RCW'(1);
         end
         if (nxt == S_CSET) begin
            dram_a      <= take ? m_col : cur_col;
            dram_we_n   <= take ? !req_wr : !cur_wr;
            dram_dq_oe  <= take ? req_wr : cur_wr;
            dram_dq_out <= take ? req_wdata : cur_wd;
         end
         if (state == S_CSET) begin
            dram_cas_n <= 1'b0;
            dram_oe_n  <= cur_wr;
         end
         if (state == S_CLO && nxt == S_CHI) begin
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
         end
         if (state == S_OPEN && nxt == S_PRE) dram_ras_n <= 1'b1;
         if (fire) dram_oe_n <= 1'b1;
      end
   end

   // R8: memory output enable and controller drive never overlap
   a_r8_bus_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(dram_dq_oe && !dram_oe_n));
   // R5: RAS low time stays inside the budget
   a_r5_ras_budget: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_ras_n |-> (int'(ras_cnt) < RAS_MAX));
   // R2: a column strobe only falls inside an open row
   a_r2_cas_in_row: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_cas_n) |-> !dram_ras_n);
   // R1: address pins hold while CAS is low
   a_r1_col_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_a));
   // R6: WE and write data hold while CAS is low
   a_r6_we_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n && $past(!dram_cas_n)) |-> ($stable(dram_we_n) && $stable(dram_dq_oe)));
   // R9: acknowledge is a single-clock pulse
   a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);
   // R7: read valid is a single-clock pulse
   a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   // R10: granted memory is idle and released
   a_r10_gnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ref_gnt |-> (dram_ras_n && dram_cas_n && dram_oe_n && !dram_dq_oe));
endmodule

// File: tb/edo_page_seq_test.sv
`timescale 1ns/1ps
module edo_page_seq_test;
   localparam int ROW_W = 3, COL_W = 3, DW = 8;
   localparam int T_RCD = 2, T_RP = 3, T_RAS = 6, T_CAS = 2, T_CP = 2;
   localparam int RD_LAT = 3, RAS_MAX = 30;
   localparam int AW = ROW_W + COL_W;
   localparam int NW = 1 << AW;
   localparam int NCOL = 1 << COL_W;
   localparam int NROW = 1 << ROW_W;
   localparam int PAGE = 1 + T_CAS + T_CP;
   localparam int C0 = T_RCD + 1 + T_CAS + T_CP;            // ras count at first open-row cycle
   localparam int PER_OPEN = 2 + (RAS_MAX - 2 - PAGE - C0) / (PAGE + 1);
   localparam int OPENS_SWEEP = NROW * ((NCOL + PER_OPEN - 1) / PER_OPEN);

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, req, req_wr, ack, rd_valid, ref_req, ref_gnt;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata, rd_data, dq_out, dq_in;
   logic ras_n, cas_n, we_n, oe_n, dq_oe;
   logic [ROW_W-1:0] dram_a;

   edo_page_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_RCD(T_RCD), .T_RP(T_RP),
      .T_RAS(T_RAS), .T_CAS(T_CAS), .T_CP(T_CP), .RD_LAT(RD_LAT), .RAS_MAX(RAS_MAX)) uut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
      .req_wdata(req_wdata), .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data),
      .ref_req(ref_req), .ref_gnt(ref_gnt), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
      .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_a(dram_a), .dram_dq_out(dq_out),
      .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

   int n_chk = 0, n_err = 0;
   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural EDO memory
   logic [7:0] mem [0:NW-1];
   logic [ROW_W-1:0] m_row;
   logic [7:0] m_word;
   logic m_act = 1'b0;
   int m_acc = 0, v_wdata = 0;
   always @(negedge ras_n) m_row = dram_a;
   always @(negedge cas_n) begin
      if (!we_n) begin
         if (dq_oe) mem[{m_row, dram_a[COL_W-1:0]}] = dq_out;
         else v_wdata++;
         m_act = 1'b0;
      end else begin
         m_word = mem[{m_row, dram_a[COL_W-1:0]}];
         m_act = 1'b1;
         m_acc = 0;
      end
   end
   always @(negedge clk) if (m_act && m_acc < 1000) m_acc++;
   assign dq_in = (!oe_n && m_act && m_acc >= 2) ? m_word : 8'hEE;

   // port monitor
   logic [7:0] shadow [0:NW-1];
   int exp_q[$];
   int cyc = 0, ras_falls = 0, cas_falls = 0, acks = 0, n_req = 0;
   int rl = 0, rh = 0, cl = 0, ch = 0, rd_cas_cyc = 0;
   int v_rcd = 0, v_rp = 0, v_ras = 0, v_max = 0, v_cas = 0, v_cp = 0, v_bus = 0, v_ack = 0;
   bit seen_rise = 0, seen_crise = 0, p_ras = 1, p_cas = 1, p_ack = 0;
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (!ras_n) begin
            if (p_ras) begin
               ras_falls++;
               if (seen_rise && rh < T_RP) v_rp++;
               rl = 0;
            end
            rl++;
         end else begin
            if (!p_ras) begin
               if (rl < T_RAS) v_ras++;
               if (rl > RAS_MAX) v_max++;
               rh = 0;
               seen_rise = 1;
            end
            rh++;
         end
         if (!cas_n) begin
            if (p_cas) begin
               cas_falls++;
               if (ras_n || rl - 1 < T_RCD) v_rcd++;
               if (seen_crise && ch < T_CP) v_cp++;
               if (we_n) rd_cas_cyc = cyc;
               cl = 0;
            end
            cl++;
         end else begin
            if (!p_cas) begin
               if (cl < T_CAS) v_cas++;
               ch = 0;
               seen_crise = 1;
            end
            ch++;
         end
         if (dq_oe && !oe_n) v_bus++;
         if (ack) begin acks++; if (p_ack) v_ack++; end
         if (rd_valid) begin
            chk(cyc - rd_cas_cyc == RD_LAT, "R7 capture latency", cyc - rd_cas_cyc, RD_LAT);
            if (exp_q.size() == 0) chk(0, "R7 unexpected read", int'(rd_data), -1);
            else begin
               automatic int e = exp_q.pop_front();
               chk(int'(rd_data) == e, "R1 R6 R7 read data", int'(rd_data), e);
            end
         end
      end
      p_ras = ras_n; p_cas = cas_n; p_ack = ack;
   end

   task automatic do_req(input bit wr, input int a, input logic [7:0] d);
      req_wr = wr; req_addr = AW'(a); req_wdata = d; req = 1'b1; n_req++;
      if (wr) shadow[a] = d;
      else exp_q.push_back(int'(shadow[a]));
      do @(negedge clk); while (!ack);
      req = 1'b0;
   endtask

   function automatic logic [7:0] pat(input int a, input int k);
      return 8'((a * 37 + 5 + k * 11) & 255);
   endfunction

   initial begin
      int r0, c0;
      bit saw;
      rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0; ref_req = 1'b0;
      repeat (4) @(negedge clk);
      // R11 reset state
      chk(ras_n && cas_n && we_n && oe_n, "R11 strobes high", {ras_n, cas_n, we_n, oe_n}, 15);
      chk(!dq_oe && !ack && !rd_valid && !ref_gnt, "R11 outputs idle",
          {dq_oe, ack, rd_valid, ref_gnt}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // write sweep: page hits along each row, budget-limited
      r0 = ras_falls; c0 = cas_falls;
      for (int a = 0; a < NW; a++) do_req(1'b1, a, pat(a, 0));
      repeat (40) @(negedge clk);
      chk(ras_falls - r0 == OPENS_SWEEP, "R5 row openings in write sweep", ras_falls - r0, OPENS_SWEEP);
      chk((cas_falls - c0) - (ras_falls - r0) == NW - OPENS_SWEEP, "R3 page hits in write sweep",
          (cas_falls - c0) - (ras_falls - r0), NW - OPENS_SWEEP);

      // read sweep
      r0 = ras_falls; c0 = cas_falls;
      for (int a = 0; a < NW; a++) do_req(1'b0, a, 8'h00);
      repeat (40) @(negedge clk);
      chk(ras_falls - r0 == OPENS_SWEEP, "R5 row openings in read sweep", ras_falls - r0, OPENS_SWEEP);
      chk(cas_falls - c0 == NW, "R3 one column cycle per read", cas_falls - c0, NW);

      // alternating rows: every request is a row miss
      r0 = ras_falls;
      for (int i = 0; i < 16; i++) do_req(1'b0, ((i % 2) ? 5 : 2) * NCOL + (i % NCOL), 8'h00);
      repeat (40) @(negedge clk);
      chk(ras_falls - r0 == 16, "R4 new row per miss", ras_falls - r0, 16);

      // reverse order overwrite, mixed read-after-write in one page
      for (int a = NW - 1; a >= 0; a--) do_req(1'b1, a, pat(a, 1));
      do_req(1'b1, 20, 8'h5A); do_req(1'b0, 20, 8'h00);
      do_req(1'b1, 21, 8'hA5); do_req(1'b0, 21, 8'h00); do_req(1'b0, 20, 8'h00);
      for (int a = 0; a < NW; a += 3) do_req(1'b0, a, 8'h00);
      repeat (40) @(negedge clk);

      // refresh grant
      do_req(1'b0, 9, 8'h00);
      ref_req = 1'b1;
      begin
         int w = 0;
         while (!ref_gnt && w < 200) begin @(negedge clk); w++; end
         chk(ref_gnt, "R10 grant reached", int'(ref_gnt), 1);
      end
      chk(ras_n && cas_n && oe_n && !dq_oe, "R10 memory released", {ras_n, cas_n, oe_n, dq_oe}, 14);
      req_wr = 1'b0; req_addr = AW'(50); req = 1'b1; n_req++;
      exp_q.push_back(int'(shadow[50]));
      saw = 0;
      repeat (8) begin @(negedge clk); if (ack) saw = 1; end
      chk(!saw, "R10 no accept during grant", int'(saw), 0);
      ref_req = 1'b0;
      do @(negedge clk); while (!ack);
      req = 1'b0;
      repeat (40) @(negedge clk);

      chk(v_rcd == 0, "R2 RAS-to-CAS violations", v_rcd, 0);
      chk(v_rp == 0 && v_ras == 0, "R2 RAS precharge/low violations", v_rp + v_ras, 0);
      chk(v_cas == 0 && v_cp == 0, "R2 CAS low/high violations", v_cas + v_cp, 0);
      chk(v_max == 0, "R5 RAS budget overruns", v_max, 0);
      chk(v_bus == 0, "R8 bus conflicts", v_bus, 0);
      chk(v_wdata == 0, "R6 write without drive", v_wdata, 0);
      chk(acks == n_req && v_ack == 0, "R9 ack count", acks, n_req);
      chk(exp_q.size() == 0, "R7 reads outstanding", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule